// File: doc/BRIEF.md
# Phase-Accumulator Timed Serial Line Transmitter

This block drives one output line with asynchronous serial frames. Software configures it through three write ports: a 5-bit mode word, a 32-bit configuration word and a 32-bit data word. Only one mode code turns the transmitter on. The configuration word holds a 16-bit rate increment and the frame's data length.

Bit timing does not come from an integer divider. On every clock the rate increment is added to a 16-bit phase accumulator, and each carry out of that accumulator ends one bit period. The increment is chosen as round(65536 × baud / clock). Fractional ratios therefore give bit periods whose average is exact, even though any single period can jitter by one clock.

Writing the data word starts a frame: a low start bit, then the data bits LSB first, then a high stop bit. Software polls `busy` and waits for it to drop before writing the next word. It can also watch the completion flag `done`, which it clears with a one-cycle `ack`. After a mode write, `done` stays low until a frame has actually finished.

Top module: `nco_uart_tx`

## Requirements
- R1: Transmission is enabled only while the mode register holds 5'b11110. In any other mode, including 5'b11111 (the receive code), a data write starts nothing, `busy` stays low and `txd` stays high.
- R2: The line idles high. A frame is one low start bit, then the data bits sent LSB first (bit 0 of the data word goes first), then one high stop bit.
- R3: Bits [31:16] of the configuration word are the phase increment. The 16-bit accumulator is cleared on the edge that accepts a data write. It adds the increment on every later clock, and each carry out ends the current bit.
- R4: Bits [4:0] of the configuration word hold the data length minus one. A value of 7 gives 8 data bits, 0 gives 1 and 31 gives 32.
- R5: `busy` and the start bit both appear on the edge that accepts the data write. `busy` stays high until the edge on which the stop bit's carry occurs. A data write while `busy` is high is ignored and does not alter the frame in progress.
- R6: `done` is low after reset and after any mode write. It rises on the same edge on which `busy` falls at the end of a stop bit.
- R7: A high `ack` clears `done` on the next edge. If a frame completes in the same cycle, the completion wins and `done` stays high. `done` falls for no other reason than an ack or a mode write.
- R8: A reset or a mode write, even in the middle of a frame, clears the accumulator, the shifter, `busy` and `done`, and returns `txd` high. The next frame then starts from a zero phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 5 | Mode value; 5'b11110 selects transmit |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | [31:16] phase increment, [4:0] data length minus one |
| data_we | input | 1 | Write strobe for the data word; starts a frame |
| data_wdata | input | 32 | Data to send, LSB first |
| ack | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial output line |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | Completion flag, set at the end of a stop bit |

## Verification
Two situations are hard to reach from the ports: a write that arrives while a frame is being sent, and a mode write that aborts a frame partway through. The frame task accepts an optional cycle number. At that cycle it injects a second data write with inverted data, then checks the whole waveform against the first word. A directed case issues a mode write in the middle of a frame and checks that the line goes high. It then sends a fresh frame and checks that its timing assumes a zero starting phase. The frame table includes fractional increments, so uneven bit lengths are compared cycle by cycle against a phase model kept in the bench.

// File: rtl/nco_uart_tx_pkg.sv
// Shared constants and types for the phase-accumulator serial transmitter.
// Assumes: mode codes are 5 bits wide; the configuration layout is fixed.
package nco_uart_tx_pkg;
    localparam int MODE_W   = 5;
    localparam int CFG_W    = 32;
    localparam logic [MODE_W-1:0] MODE_ASYNC_TX = 5'b11110;
    localparam logic [MODE_W-1:0] MODE_ASYNC_RX = 5'b11111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/nco_uart_cfg_regs.sv
// Holds the mode and configuration words written by the host.
// Decodes the transmit enable, the phase increment and the data length.
// Assumes: the increment sits in the top PHASE_W bits of the configuration
// word and the length minus one sits in the low LEN_W bits.
module nco_uart_cfg_regs
    import nco_uart_tx_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int LEN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_we,
    input  logic [MODE_W-1:0]  mode_wdata,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic               tx_en,
    output logic [PHASE_W-1:0] phase_inc,
    output logic [LEN_W-1:0]   len_m1
);
    localparam int INC_LSB = CFG_W - PHASE_W;

    logic [MODE_W-1:0] mode_q;
    logic [CFG_W-1:0]  cfg_q;

    // Latch the mode word on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    // Latch the configuration word on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    // Decode the fields that the datapath uses.
    always_comb begin
        tx_en     = (mode_q == MODE_ASYNC_TX);
        phase_inc = cfg_q[CFG_W-1:INC_LSB];
        len_m1    = cfg_q[LEN_W-1:0];
    end
endmodule

// File: rtl/nco_phase_tick.sv
// Fractional bit-rate generator. While run is high it adds the increment to
// a PHASE_W-bit accumulator on every clock, and each carry out is a tick.
// Assumes: clr has priority over run; a zero increment never ticks.
module nco_phase_tick #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic [PHASE_W-1:0] inc,
    output logic               tick
);
    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W:0]   sum;

    // Form the next phase; its top bit is the carry.
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, inc};
        tick = run && sum[PHASE_W];
    end

    // Clear on frame start or abort; otherwise advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (run)      acc_q <= sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/nco_uart_shifter.sv
// Frame sequencer: start bit, LSB-first data, stop bit. It advances one bit
// per tick, raises done at the end of the stop bit, and ignores loads while
// a frame is in flight.
// Assumes: abort (a mode write) has priority over every other input.
module nco_uart_shifter
    import nco_uart_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              tick,
    input  logic              ack,
    output logic              busy,
    output logic              accept,
    output logic              txd,
    output logic              done
);
    tx_state_t         state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [LEN_W-1:0]  left_q;
    logic              finish;

    // A load is taken only when no frame is in progress.
    always_comb begin
        busy   = (state_q != ST_IDLE);
        accept = load && !busy;
        finish = (state_q == ST_STOP) && tick;
    end

    // Line level follows the current frame position.
    always_comb begin
        unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg_q[0];
            default:  txd = 1'b1;
        endcase
    end

    // Step through the frame fields, one per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_START;
                    shreg_q <= load_data;
                    left_q  <= len_m1;
                end
                ST_START: if (tick) state_q <= ST_DATA;
                ST_DATA: if (tick) begin
                    if (left_q == '0) begin
                        state_q <= ST_STOP;
                    end else begin
                        shreg_q <= shreg_q >> 1;
                        left_q  <= left_q - 1'b1;
                    end
                end
                ST_STOP: if (tick) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion flag: set at the end of the stop bit (wins over ack), cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) done <= 1'b0;
        else if (finish)     done <= 1'b1;
        else if (ack)        done <= 1'b0;
    end
endmodule

// File: rtl/nco_uart_tx.sv
// Top level of the phase-accumulator serial transmitter. It joins the
// register decode, the bit-rate generator and the frame sequencer.
// Assumes: all host strobes are synchronous single-cycle pulses.
module nco_uart_tx
    import nco_uart_tx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PHASE_W = 16,
    parameter int LEN_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [4:0]        mode_wdata,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ack,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    logic               tx_en;
    logic [PHASE_W-1:0] phase_inc;
    logic [LEN_W-1:0]   len_m1;
    logic               tick;
    logic               accept;

    nco_uart_cfg_regs #(.PHASE_W(PHASE_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_en(tx_en), .phase_inc(phase_inc), .len_m1(len_m1)
    );

    nco_phase_tick #(.PHASE_W(PHASE_W)) u_nco (
        .clk(clk), .rst_n(rst_n),
        .clr(mode_we || accept), .run(busy),
        .inc(phase_inc), .tick(tick)
    );

    nco_uart_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .abort(mode_we), .load(data_we && tx_en),
        .load_data(data_wdata), .len_m1(len_m1),
        .tick(tick), .ack(ack),
        .busy(busy), .accept(accept), .txd(txd), .done(done)
    );
endmodule

// File: rtl/nco_uart_tx_chk.sv
// Port-level protocol checker for the transmitter, attached by bind.
module nco_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_we,
    input logic ack,
    input logic txd,
    input logic busy,
    input logic done
);
    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    // R5
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    // R6
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(mode_we)) |-> done);
    // R8
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (!busy && !done && txd));
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !busy && !mode_we) |=> !done);
    // R7
    done_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> ($past(ack) || $past(mode_we)));
endmodule

bind nco_uart_tx nco_uart_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .ack(ack),
    .txd(txd), .busy(busy), .done(done)
);

// File: tb/nco_uart_tx_test.sv
module nco_uart_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [4:0]  mode_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        data_we = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        ack = 1'b0;
    logic        txd, busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nco_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .data_we(data_we),
        .data_wdata(data_wdata), .ack(ack), .txd(txd), .busy(busy), .done(done)
    );

    // Frame table: {increment[15:0], length-1[4:0], data[31:0]}
    localparam logic [52:0] VECS [0:6] = '{
        {16'h4000, 5'd7,  32'h0000_00A5},
        {16'h8000, 5'd7,  32'h0000_003C},
        {16'h5556, 5'd7,  32'h0000_0081},
        {16'h2000, 5'd4,  32'h0000_0013},
        {16'hFFFF, 5'd0,  32'h0000_0001},
        {16'h3000, 5'd15, 32'h0000_BEEF},
        {16'h6000, 5'd31, 32'h8000_0001}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [4:0] m);
        @(negedge clk); mode_wdata = m; mode_we = 1'b1;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [15:0] inc, input logic [4:0] nm1);
        @(negedge clk); cfg_wdata = {inc, 11'd0, nm1}; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    // Send one frame and compare txd/busy/done every cycle with a phase model.
    // inject >= 0 issues an extra write of inverted data at that cycle.
    task automatic send_frame(input logic [15:0] inc, input logic [4:0] nm1,
                              input logic [31:0] d, input int inject,
                              input string req);
        int   idx = 0;
        int   cyc = 0;
        int   bad = 0;
        int   last = int'(nm1) + 3;
        logic [16:0] sum;
        logic [15:0] acc = '0;
        logic exp_txd;
        @(negedge clk); data_wdata = d; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
        while (idx < last && cyc < 4000) begin
            if (idx == 0) exp_txd = 1'b0;
            else if (idx <= int'(nm1) + 1) exp_txd = d[idx-1];
            else exp_txd = 1'b1;
            if (txd !== exp_txd || busy !== 1'b1 || done !== 1'b0) begin
                if (bad == 0)
                    $display("FAIL %s waveform cyc=%0d bit=%0d actual=%0h expected=%0h",
                             req, cyc, idx, {txd, busy, done}, {exp_txd, 2'b10});
                bad++;
            end
            data_we = (cyc == inject);
            data_wdata = ~d;
            @(negedge clk);
            data_we = 1'b0;
            sum = {1'b0, acc} + {1'b0, inc};
            acc = sum[15:0];
            if (sum[16]) idx++;
            cyc++;
        end
        checks++;
        if (bad != 0) failures++;
        check(busy === 1'b0 && done === 1'b1 && txd === 1'b1, "R6",
              "end of frame {txd,busy,done}", {txd, busy, done}, 3'b101);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R8",
              "reset {txd,busy,done}", {txd, busy, done}, 3'b100);

        // R1 receive mode: data write starts nothing
        wr_mode(5'b11111);
        wr_cfg(16'h4000, 5'd7);
        @(negedge clk); data_wdata = 32'h00; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
        repeat (3) @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R1", "rx mode {txd,busy}",
              {txd, busy}, 2'b10);

        // R6 done stays low after entering transmit mode, before any frame
        wr_mode(5'b11110);
        repeat (4) @(negedge clk);
        check(done === 1'b0, "R6", "done before first frame", done, 0);

        // R2 R3 R4 table of frames
        foreach (VECS[i]) begin
            wr_cfg(VECS[i][52:37], VECS[i][36:32]);
            if (done) begin
                pulse_ack();
                // R7 ack clears done
                check(done === 1'b0, "R7", "done after ack", done, 0);
            end
            send_frame(VECS[i][52:37], VECS[i][36:32], VECS[i][31:0], -1, "R2_R3_R4");
        end

        // R5 write while busy is ignored
        wr_cfg(16'h4000, 5'd7);
        pulse_ack();
        send_frame(16'h4000, 5'd7, 32'h0000_0055, 9, "R5");

        // R8 mode write mid-frame aborts, then a fresh frame starts from zero phase
        pulse_ack();
        @(negedge clk); data_wdata = 32'h00; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
        repeat (6) @(negedge clk);
        wr_mode(5'b11110);
        check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R8",
              "abort {txd,busy,done}", {txd, busy, done}, 3'b100);
        wr_cfg(16'h5556, 5'd7);
        send_frame(16'h5556, 5'd7, 32'h0000_00C3, -1, "R8");

        // R6 mode write clears a set done
        wr_mode(5'b11110);
        check(done === 1'b0, "R6", "done after mode write", done, 0);

        // R1 leaving transmit mode: data write ignored
        wr_mode(5'b00000);
        @(negedge clk); data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && txd === 1'b1, "R1", "mode 0 {txd,busy}",
              {txd, busy}, 2'b10);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule